// File: doc/BRIEF.md
# I2C 16-bit Register-File Target

This block is an I2C target that gives a display controller a bank of sixteen-bit configuration and status registers. An 8-bit index selects each register, so the index space has 256 entries. The block takes SCL and SDA as sampled, synchronous levels. It drives one output that enables an SDA pull-low. The open-drain pad sits outside the block. The register contents reach the panel logic as plain level pins, and one plain input reports the panel's power-down state. The block has no streaming data interface, so there is no valid/ready back-pressure at its edge. The I2C clock sets the pace of every transfer.

A write is one addressed message of three bytes: the register index, the low data byte, then the high data byte. A read uses an unusual three-step sequence, with no repeated START inside it:
1. The host sends an address byte with the read bit set.
2. The host then sends the register index as an ordinary byte.
3. The target returns two bytes, low byte first.

Register 0x00 echoes the target's own 7-bit bus address, so a host can confirm it is talking to the right device. A few other indices have special behaviour:
- a power/enable control register, with an interlock between the LCD enable and repeater bypass;
- an interface-format register;
- a read-only panel status register;
- a parameterised window of general read/write registers.

Every other index reads as zero.

Top module: `i2crf_top`

## Requirements
- R1: The target pulls SDA low for the ninth (acknowledge) clock of an address byte whose bits 7:1 equal DEV_ADDR, whatever the state of bit 0 (1 = read). For any other address it does not acknowledge, keeps SDA released until the next START, and changes no register.
- R2: After an acknowledged write address, the first byte is the index, the second is data bits 7:0 and the third is data bits 15:8. The register is updated only when the third byte completes. Every byte is acknowledged, and bytes after the third are acknowledged and ignored.
- R3: After an acknowledged read address, the next byte is taken as the index and acknowledged. The target then sends data bits 7:0 and then bits 15:8, each MSB first. After the second byte it releases SDA.
- R4: Index 0x00 reads as {9'b0, DEV_ADDR}. Writes to it have no effect.
- R5: Index 0x01 holds four bits: bit 0 drives `pclk_en_o`, bit 1 `bypass_en_o`, bit 2 `lcd_en_o` and bit 3 `fit_en_o`. Bits 15:4 read as zero.
- R6: A write to index 0x01 with bit 1 set stores bit 2 as zero, whatever was written, so the LCD enable is refused while bypass is set.
- R7: Index 0x10 bit 4 drives `lvds_sel_o` (1 = LVDS, 0 = CMOS). Bits 3:2 drive `if_fmt_o` (0 = 1x18, 1 = 1x24, 2 = 2x18, 3 = 2x24). All other bits read as zero.
- R8: Index 0x30 bit 15 reads the level of `panel_busy_i` (1 = panel not yet safely off). All other bits read as zero, and writes have no effect.
- R9: Indices GEN_BASE to GEN_BASE+GEN_NUM-1 are full 16-bit read/write registers. Every index not named in R4 to R9 reads as zero.
- R10: While `rst_n` is low, and right after it rises, SDA is released, all control outputs are zero and every writable register reads zero.
- R11: A STOP returns the target to idle and releases SDA. A START at any point restarts the address phase. A write cut short by a STOP or START before its third byte completes changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; SCL and SDA are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level as seen on the bus |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| panel_busy_i | input | 1 | 1 = panel not yet in a safe powered-off state |
| pclk_en_o | output | 1 | Output clock enable (index 0x01 bit 0) |
| bypass_en_o | output | 1 | Repeater bypass enable (index 0x01 bit 1) |
| lcd_en_o | output | 1 | LCD enable (index 0x01 bit 2) |
| fit_en_o | output | 1 | Panel fitter enable (index 0x01 bit 3) |
| lvds_sel_o | output | 1 | 1 = LVDS, 0 = CMOS (index 0x10 bit 4) |
| if_fmt_o | output | 2 | Interface format code (index 0x10 bits 3:2) |

## Verification
The bench builds the target with DEV_ADDR = 7'h53, GEN_BASE = 8'h40 and GEN_NUM = 4. It addresses a neighbour at 7'h52, which differs only in the least significant address bit, so the acknowledge decision has to compare every address bit. With the window at 0x40 to 0x43, the indices just below and just above it (0x3F and 0x44) can be reached and must read zero. Index 0x30 lies close by and must still show only the panel-status bit. An odd device address also makes the identity echo carry a set bit 0.

// File: rtl/i2crf_pkg.sv
package i2crf_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_W  = 16;
  localparam int IDX_W  = 8;
  localparam int ADR_W  = 7;

  localparam logic [IDX_W-1:0] IDX_ID   = 8'h00;
  localparam logic [IDX_W-1:0] IDX_CTRL = 8'h01;
  localparam logic [IDX_W-1:0] IDX_FMT  = 8'h10;
  localparam logic [IDX_W-1:0] IDX_STAT = 8'h30;

  localparam int CTRL_W = 4;
  localparam int FMT_W  = 3;

  typedef enum logic [2:0] {
    LK_IDLE, LK_RX, LK_ACKW, LK_ACK, LK_TX, LK_TXACK, LK_IGNORE
  } lk_state_e;

  typedef enum logic [2:0] {
    PH_ADDR, PH_INDEX, PH_LO, PH_HI, PH_EXTRA
  } phase_e;
endpackage

// File: rtl/i2crf_cond.sv
module i2crf_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2crf_link.sv
module i2crf_link
  import i2crf_pkg::*;
#(
  parameter logic [ADR_W-1:0] DEV_ADDR = 7'h44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_i,
  output logic             sda_pull,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [REG_W-1:0] wr_data,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [REG_W-1:0] rd_data
);
  lk_state_e         state;
  phase_e            phase;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh, hi_hold, lo_q, idx_q;
  logic              rd_mode;
  logic [BYTE_W-1:0] rx_next;

  assign rx_next = {rx_sh[BYTE_W-2:0], sda_i};
  assign wr_idx  = idx_q;
  assign rd_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= LK_IDLE;
      phase    <= PH_ADDR;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      hi_hold  <= '0;
      lo_q     <= '0;
      idx_q    <= '0;
      rd_mode  <= 1'b0;
      sda_pull <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= LK_RX;
        phase    <= PH_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= LK_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          LK_RX: if (scl_rise) begin
            rx_sh <= rx_next;
            cnt   <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              state <= LK_ACKW;
              case (phase)
                PH_ADDR: begin
                  rd_mode <= rx_next[0];
                  if (rx_next[BYTE_W-1:1] != DEV_ADDR) state <= LK_IGNORE;
                end
                PH_INDEX: idx_q <= rx_next;
                PH_LO:    lo_q  <= rx_next;
                PH_HI: begin
                  wr_en   <= 1'b1;
                  wr_data <= {rx_next, lo_q};
                end
                default: ;
              endcase
            end
          end
          LK_ACKW: if (scl_fall) begin
            sda_pull <= 1'b1;
            state    <= LK_ACK;
          end
          LK_ACK: if (scl_fall) begin
            sda_pull <= 1'b0;
            cnt      <= '0;
            state    <= LK_RX;
            case (phase)
              PH_ADDR:  phase <= PH_INDEX;
              PH_INDEX: begin
                if (rd_mode) begin
                  state    <= LK_TX;
                  phase    <= PH_LO;
                  tx_sh    <= rd_data[BYTE_W-1:0];
                  hi_hold  <= rd_data[REG_W-1:BYTE_W];
                  sda_pull <= ~rd_data[BYTE_W-1];
                end else begin
                  phase <= PH_LO;
                end
              end
              PH_LO:   phase <= PH_HI;
              default: phase <= PH_EXTRA;
            endcase
          end
          LK_TX: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_pull <= 1'b0;
                state    <= LK_TXACK;
              end else begin
                tx_sh    <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_pull <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          LK_TXACK: if (scl_fall) begin
            cnt <= '0;
            if (phase == PH_LO) begin
              phase    <= PH_HI;
              state    <= LK_TX;
              tx_sh    <= hi_hold;
              sda_pull <= ~hi_hold[BYTE_W-1];
            end else begin
              state    <= LK_IGNORE;
              sda_pull <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1: a foreign or finished transaction leaves SDA alone
  assert_foreign_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_IGNORE) |-> !sda_pull);
  // R11: STOP always brings the link back to idle with SDA released
  assert_stop_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == LK_IDLE && !sda_pull));
  // R2: a register commit is a single-cycle pulse
  assert_commit_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
  // R3: a transmitted bit does not change on the SCL rising edge
  assert_tx_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && state == LK_TX) |=> $stable(sda_pull));
endmodule

// File: rtl/i2crf_regs.sv
module i2crf_regs
  import i2crf_pkg::*;
#(
  parameter logic [ADR_W-1:0] DEV_ADDR = 7'h44,
  parameter logic [IDX_W-1:0] GEN_BASE = 8'h40,
  parameter int               GEN_NUM  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [REG_W-1:0]  rd_data,
  input  logic              panel_busy,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [FMT_W-1:0]  fmt_o
);
  logic [CTRL_W-1:0]             ctrl_q;
  logic [FMT_W-1:0]              fmt_q;
  logic [GEN_NUM-1:0][REG_W-1:0] gen_flat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fmt_q  <= '0;
    end else if (wr_en) begin
      if (wr_idx == IDX_CTRL)
        ctrl_q <= {wr_data[3], wr_data[2] & ~wr_data[1], wr_data[1:0]};
      if (wr_idx == IDX_FMT)
        fmt_q <= wr_data[4:2];
    end
  end

  for (genvar g = 0; g < GEN_NUM; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = GEN_BASE + IDX_W'(g);
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                           q <= '0;
      else if (wr_en && wr_idx == SLOT)     q <= wr_data;
    end
    assign gen_flat[g] = q;
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx == IDX_ID)        rd_data = {{(REG_W-ADR_W){1'b0}}, DEV_ADDR};
    else if (rd_idx == IDX_CTRL) rd_data = {{(REG_W-CTRL_W){1'b0}}, ctrl_q};
    else if (rd_idx == IDX_FMT)  rd_data = {{(REG_W-FMT_W-2){1'b0}}, fmt_q, 2'b00};
    else if (rd_idx == IDX_STAT) rd_data = {panel_busy, {(REG_W-1){1'b0}}};
    for (int g = 0; g < GEN_NUM; g++)
      if (rd_idx == GEN_BASE + IDX_W'(g)) rd_data = gen_flat[g];
  end

  assign ctrl_o = ctrl_q;
  assign fmt_o  = fmt_q;

  // R6: the stored LCD enable is never set together with bypass
  assert_lcd_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[1] |-> !ctrl_q[2]);
  // R5: the control bits move only on a write addressed to them
  assert_ctrl_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx == IDX_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/i2crf_top.sv
module i2crf_top
  import i2crf_pkg::*;
#(
  parameter logic [ADR_W-1:0] DEV_ADDR = 7'h44,
  parameter logic [IDX_W-1:0] GEN_BASE = 8'h40,
  parameter int               GEN_NUM  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic       panel_busy_i,
  output logic       pclk_en_o,
  output logic       bypass_en_o,
  output logic       lcd_en_o,
  output logic       fit_en_o,
  output logic       lvds_sel_o,
  output logic [1:0] if_fmt_o
);
  logic             scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [REG_W-1:0] wr_data, rd_data;
  logic [CTRL_W-1:0] ctrl;
  logic [FMT_W-1:0]  fmt;

  i2crf_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2crf_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_i(sda_i),
    .sda_pull(sda_pull_o), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  i2crf_regs #(.DEV_ADDR(DEV_ADDR), .GEN_BASE(GEN_BASE), .GEN_NUM(GEN_NUM)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .panel_busy(panel_busy_i), .ctrl_o(ctrl), .fmt_o(fmt)
  );

  assign pclk_en_o   = ctrl[0];
  assign bypass_en_o = ctrl[1];
  assign lcd_en_o    = ctrl[2];
  assign fit_en_o    = ctrl[3];
  assign lvds_sel_o  = fmt[2];
  assign if_fmt_o    = fmt[1:0];
endmodule

// File: tb/tb_i2crf_top.sv
module tb_i2crf_top;
  localparam logic [6:0] DEV = 7'h53;
  localparam logic [6:0] FOREIGN = 7'h52;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic panel_busy = 1'b0;
  logic sda_bus, sda_pull;
  logic pclk_en, bypass_en, lcd_en, fit_en, lvds_sel;
  logic [1:0] if_fmt;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q[$];
  logic [15:0] act_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;
  assign sda_bus = sda_h & ~sda_pull;

  i2crf_top #(.DEV_ADDR(DEV), .GEN_BASE(8'h40), .GEN_NUM(4)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .panel_busy_i(panel_busy),
    .pclk_en_o(pclk_en), .bypass_en_o(bypass_en), .lcd_en_o(lcd_en),
    .fit_en_o(fit_en), .lvds_sel_o(lvds_sel), .if_fmt_o(if_fmt)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wait_q(1);
    scl_h = 1'b1; wait_q(2);
    sda_h = 1'b0; wait_q(2);
    scl_h = 1'b0; wait_q(1);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wait_q(1);
    scl_h = 1'b1; wait_q(2);
    sda_h = 1'b1; wait_q(2);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wait_q(1);
      scl_h = 1'b1; wait_q(2);
      scl_h = 1'b0; wait_q(1);
    end
    sda_h = 1'b1; wait_q(1);
    scl_h = 1'b1; wait_q(1);
    acked = (sda_bus == 1'b0);
    wait_q(1);
    scl_h = 1'b0; wait_q(1);
  endtask

  task automatic get_byte(input bit host_ack, output logic [7:0] b);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q(1);
      scl_h = 1'b1; wait_q(1);
      b[i] = sda_bus;
      wait_q(1);
      scl_h = 1'b0; wait_q(1);
    end
    sda_h = host_ack ? 1'b0 : 1'b1; wait_q(1);
    scl_h = 1'b1; wait_q(2);
    scl_h = 1'b0; wait_q(1);
    sda_h = 1'b1;
  endtask

  // R2: own-address write of index, low byte, high byte
  task automatic wr_reg(input logic [7:0] idx, input logic [15:0] val);
    bit a0, a1, a2, a3;
    bus_start();
    put_byte({DEV, 1'b0}, a0);
    put_byte(idx, a1);
    put_byte(val[7:0], a2);
    put_byte(val[15:8], a3);
    bus_stop();
    chk(a0 && a1 && a2 && a3, "R2 write acks", {a0, a1, a2, a3}, 4'hF);
  endtask

  // R3: read sequence; expected value pushed to the scoreboard
  task automatic rd_expect(input logic [7:0] idx, input logic [15:0] exp, input string tag);
    bit a0, a1, rel;
    logic [7:0] lo, hi;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_start();
    put_byte({DEV, 1'b1}, a0);
    put_byte(idx, a1);
    get_byte(1'b1, lo);
    get_byte(1'b0, hi);
    rel = (sda_pull == 1'b0);
    bus_stop();
    act_q.push_back({hi, lo});
    chk(a0 && a1, "R3 read acks", {a0, a1}, 2'b11);
    chk(rel, "R3 release after high byte", rel, 1);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [15:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(a == e, t, a, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit a0, a1, a2, a3;
    logic [7:0] b0, b1;
    repeat (6) @(negedge clk);
    // R10: reset state
    chk(!sda_pull && !pclk_en && !bypass_en && !lcd_en && !fit_en && !lvds_sel && if_fmt == 2'd0,
        "R10 outputs in reset", {sda_pull, pclk_en, bypass_en, lcd_en, fit_en, lvds_sel, if_fmt}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sda_pull && !pclk_en && !lcd_en && if_fmt == 2'd0, "R10 outputs after reset",
        {sda_pull, pclk_en, lcd_en, if_fmt}, 0);
    rd_expect(8'h41, 16'h0000, "R10 window cleared");

    // R4: identity echo and read-only
    rd_expect(8'h00, {9'd0, DEV}, "R4 identity");
    wr_reg(8'h00, 16'hFFFF);
    rd_expect(8'h00, {9'd0, DEV}, "R4 identity after write");

    // R5: control bits
    wr_reg(8'h01, 16'h0009);
    chk(pclk_en && fit_en && !lcd_en && !bypass_en, "R5 pins 0x0009",
        {fit_en, lcd_en, bypass_en, pclk_en}, 4'b1001);
    rd_expect(8'h01, 16'h0009, "R5 readback");
    wr_reg(8'h01, 16'hFFF4);
    chk(lcd_en && !pclk_en && !fit_en && !bypass_en, "R5 pins 0xFFF4",
        {fit_en, lcd_en, bypass_en, pclk_en}, 4'b0100);
    rd_expect(8'h01, 16'h0004, "R5 upper bits zero");

    // R6: LCD enable refused with bypass
    wr_reg(8'h01, 16'h0006);
    chk(bypass_en && !lcd_en, "R6 pins", {lcd_en, bypass_en}, 2'b01);
    rd_expect(8'h01, 16'h0002, "R6 readback");

    // R7: interface format
    wr_reg(8'h10, 16'h001C);
    chk(lvds_sel && if_fmt == 2'd3, "R7 lvds 2x24", {lvds_sel, if_fmt}, 3'b111);
    rd_expect(8'h10, 16'h001C, "R7 readback 0x1C");
    wr_reg(8'h10, 16'hFFEB);
    chk(!lvds_sel && if_fmt == 2'd2, "R7 cmos 2x18", {lvds_sel, if_fmt}, 3'b010);
    rd_expect(8'h10, 16'h0008, "R7 readback masked");

    // R8: panel status
    panel_busy = 1'b1;
    rd_expect(8'h30, 16'h8000, "R8 busy");
    wr_reg(8'h30, 16'hFFFF);
    panel_busy = 1'b0;
    rd_expect(8'h30, 16'h0000, "R8 idle after write");

    // R9: general window and unimplemented indices
    wr_reg(8'h40, 16'hA55A);
    wr_reg(8'h41, 16'h1234);
    wr_reg(8'h42, 16'hFF00);
    wr_reg(8'h43, 16'h00FF);
    rd_expect(8'h40, 16'hA55A, "R9 slot0");
    rd_expect(8'h41, 16'h1234, "R9 slot1");
    rd_expect(8'h42, 16'hFF00, "R9 slot2");
    rd_expect(8'h43, 16'h00FF, "R9 slot3");
    wr_reg(8'h44, 16'hBEEF);
    rd_expect(8'h44, 16'h0000, "R9 above window");
    rd_expect(8'h3F, 16'h0000, "R9 below window");
    rd_expect(8'hFF, 16'h0000, "R9 top index");

    // R1: foreign address ignored, no acknowledge, no change
    bus_start();
    put_byte({FOREIGN, 1'b0}, a0);
    put_byte(8'h40, a1);
    put_byte(8'h11, a2);
    put_byte(8'h22, a3);
    bus_stop();
    chk(!a0 && !a1 && !a2 && !a3, "R1 foreign write no ack", {a0, a1, a2, a3}, 0);
    rd_expect(8'h40, 16'hA55A, "R1 foreign write no effect");
    bus_start();
    put_byte({FOREIGN, 1'b1}, a0);
    put_byte(8'h00, a1);
    get_byte(1'b1, b0);
    get_byte(1'b0, b1);
    bus_stop();
    chk(!a0 && !a1 && b0 == 8'hFF && b1 == 8'hFF, "R1 foreign read released",
        {a0, a1, b0, b1}, {2'b00, 16'hFFFF});

    // R2: extra bytes acknowledged and ignored
    bus_start();
    put_byte({DEV, 1'b0}, a0);
    put_byte(8'h42, a1);
    put_byte(8'h34, a2);
    put_byte(8'h12, a3);
    put_byte(8'h99, a0);
    bus_stop();
    chk(a0, "R2 extra byte ack", a0, 1);
    rd_expect(8'h42, 16'h1234, "R2 extra byte ignored");

    // R11: write cut by STOP after low byte
    bus_start();
    put_byte({DEV, 1'b0}, a0);
    put_byte(8'h40, a1);
    put_byte(8'h77, a2);
    bus_stop();
    chk(!sda_pull, "R11 released after stop", sda_pull, 0);
    rd_expect(8'h40, 16'hA55A, "R11 stop aborts write");
    // R11: write cut by repeated START
    bus_start();
    put_byte({DEV, 1'b0}, a0);
    put_byte(8'h41, a1);
    put_byte(8'hAA, a2);
    rd_expect(8'h41, 16'h1234, "R11 start aborts write");

    // R10: reset clears writable state
    @(negedge clk);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!bypass_en && !lvds_sel && if_fmt == 2'd0, "R10 outputs after second reset",
        {bypass_en, lvds_sel, if_fmt}, 0);
    rd_expect(8'h40, 16'h0000, "R10 slot cleared");

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0 && act_q.size() == 0, "scoreboard drained",
        exp_q.size() + act_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule